// File: doc/BRIEF.md
# Floating-Point Exception Status and Trap Unit

This unit sits beside a floating-point datapath and owns its 32-bit status word. When the datapath finishes an operation, it strobes `op_done_i` and presents the five IEEE exception flags that the operation raised. The unit lines those flags up against the per-exception enable bits in the status word and decides whether a trap is due. On a trap it sets the trap bit in the status word, fills in an exception-record word and pulses a trap request for one cycle. Every completed operation also clears the status bits above the low 26.

The unit also decodes two controls from the status word for the datapath. The rounding-mode field becomes a one-hot rounding select. The denormal-flush bit becomes two flush enables, one for operands and one for results. The result flush acts on the result before rounding. Software can load the whole status word through a write port.

Flag and enable bit order, used on `raised_i` and in status bits [4:0]: bit 0 inexact, bit 1 underflow, bit 2 overflow, bit 3 divide-by-zero, bit 4 invalid.

Top module: `fpst_unit`

## Requirements
- R1: While `rst_ni` is low, the status word, the exception record and `trap_o` are all zero. After reset, `round_oh_o` is 4'b0001 and both flush outputs are 0.
- R2: If an operation completes with `raised_i` equal to zero, the record becomes all zeros, `trap_o` stays low and the trap bit (status bit 6) keeps its value.
- R3: After every completed operation, status bits [31:26] are zero and bits [25:0] keep their values, except that bit 6 may be set by a trap.
- R4: A completed operation traps when `raised_i & status[4:0]` is nonzero. In that case status bit 6 becomes 1 and `trap_o` is high in the cycle after the edge that takes `op_done_i`.
- R5: On a trap where the raised flags include overflow or underflow (enabled or not), the record is exactly bit 26 (condition) plus bit 29 (overflow flag), whatever else was raised.
- R6: On any other trap, the record holds the raised flags in bits [31:27], in the order given above, and all other record bits are zero.
- R7: If flags are raised but none of them is enabled, the record becomes zero, `trap_o` stays low and status bit 6 keeps its value.
- R8: Status bits [10:9] select the rounding mode, and `round_oh_o` shows it one-hot: 0 sets bit 0 (nearest-even), 1 sets bit 1 (toward zero), 2 sets bit 2 (toward +infinity), 3 sets bit 3 (toward -infinity).
- R9: Status bit 5 drives both `flush_in_o` and `flush_out_o`.
- R10: `sw_we_i` loads all 32 bits of `sw_wdata_i` into the status word. The decoded outputs follow from the next cycle. A write in the same cycle as `op_done_i` takes priority: the operation is dropped, the record is unchanged and `trap_o` stays low.
- R11: `trap_o` is high for exactly one cycle per trapping operation. It is low after any cycle with no trapping operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_done_i | input | 1 | Operation complete; qualifies `raised_i` |
| raised_i | input | 5 | Exception flags raised by the completed operation |
| sw_we_i | input | 1 | Software write strobe for the status word |
| sw_wdata_i | input | 32 | Status word write data |
| status_o | output | 32 | Current status word |
| exc_rec_o | output | 32 | Exception-record word |
| trap_o | output | 1 | One-cycle trap request |
| round_oh_o | output | 4 | One-hot rounding mode |
| flush_in_o | output | 1 | Flush denormal operands to zero |
| flush_out_o | output | 1 | Flush tiny results to zero before rounding |

## Verification
The bench targets the split in the record. If underflow is raised together with a trapped inexact, the record must still be the overflow-only form. A design that checked only the enabled overflow or underflow bits would instead copy the raw flags into bits [31:27]. Raised flags that are not enabled must clear the record and leave the trap bit alone; a design that set the trap bit on any raised flag would show a spurious trap. Software writes that put ones above bit 25, and a write that lands in the same cycle as an operation, expose a design that fails to mask the high bits or that lets the operation overwrite the loaded value.

// File: rtl/fpst_pkg.sv
package fpst_pkg;
  localparam int unsigned NFLAG       = 5;
  localparam int unsigned F_INX       = 0;
  localparam int unsigned F_UNF       = 1;
  localparam int unsigned F_OVF       = 2;
  localparam int unsigned F_DVZ       = 3;
  localparam int unsigned F_INV       = 4;
  localparam int unsigned ENA_LSB     = 0;
  localparam int unsigned D_POS       = 5;
  localparam int unsigned T_POS       = 6;
  localparam int unsigned RM_LSB      = 9;
  localparam int unsigned REC_C_POS   = 26;
  localparam int unsigned REC_FLG_LSB = 27;

  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'd0,
    RM_TO_ZERO   = 2'd1,
    RM_TO_POS    = 2'd2,
    RM_TO_NEG    = 2'd3
  } rmode_e;
endpackage

// File: rtl/fpst_trap_eval.sv
module fpst_trap_eval
  import fpst_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [NFLAG-1:0] raised_i,
  input  logic [W-1:0]     status_i,
  output logic             trap_o,
  output logic [W-1:0]     rec_o
);
  logic [NFLAG-1:0] hit;

  for (genvar i = 0; i < NFLAG; i++) begin : g_hit
    assign hit[i] = raised_i[i] & status_i[ENA_LSB+i];
  end

  assign trap_o = |hit;

  // over/underflow present (enabled or not) forces the overflow-only form
  always_comb begin
    rec_o = '0;
    if (trap_o) begin
      if (raised_i[F_OVF] | raised_i[F_UNF]) begin
        rec_o[REC_C_POS]         = 1'b1;
        rec_o[REC_FLG_LSB+F_OVF] = 1'b1;
      end else begin
        rec_o[REC_FLG_LSB +: NFLAG] = raised_i;
      end
    end
  end
endmodule

// File: rtl/fpst_ctrl_decode.sv
module fpst_ctrl_decode
  import fpst_pkg::*;
#(
  parameter int unsigned RM_W = 2,
  localparam int unsigned NRM = 1 << RM_W
) (
  input  logic [RM_W-1:0] rm_i,
  input  logic            dnorm_i,
  output logic [NRM-1:0]  round_oh_o,
  output logic            flush_in_o,
  output logic            flush_out_o
);
  for (genvar k = 0; k < NRM; k++) begin : g_rm
    assign round_oh_o[k] = (rm_i == RM_W'(k));
  end

  assign flush_in_o  = dnorm_i;
  assign flush_out_o = dnorm_i;
endmodule

// File: rtl/fpst_unit.sv
module fpst_unit
  import fpst_pkg::*;
#(
  parameter int unsigned W      = 32,
  parameter int unsigned KEEP_W = 26,
  localparam int unsigned RM_W  = 2,
  localparam int unsigned NRM   = 1 << RM_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_done_i,
  input  logic [NFLAG-1:0] raised_i,
  input  logic             sw_we_i,
  input  logic [W-1:0]     sw_wdata_i,
  output logic [W-1:0]     status_o,
  output logic [W-1:0]     exc_rec_o,
  output logic             trap_o,
  output logic [NRM-1:0]   round_oh_o,
  output logic             flush_in_o,
  output logic             flush_out_o
);
  localparam logic [W-1:0] KEEP_MASK = {{(W-KEEP_W){1'b0}}, {KEEP_W{1'b1}}};

  logic [W-1:0] status_q, rec_q, rec_d, status_upd;
  logic         trap_q, trap_d;

  fpst_trap_eval #(.W(W)) u_eval (
    .raised_i (raised_i),
    .status_i (status_q),
    .trap_o   (trap_d),
    .rec_o    (rec_d)
  );

  always_comb begin
    status_upd = status_q & KEEP_MASK;
    if (trap_d) status_upd[T_POS] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      rec_q    <= '0;
      trap_q   <= 1'b0;
    end else if (sw_we_i) begin
      status_q <= sw_wdata_i;
      trap_q   <= 1'b0;
    end else if (op_done_i) begin
      status_q <= status_upd;
      rec_q    <= rec_d;
      trap_q   <= trap_d;
    end else begin
      trap_q   <= 1'b0;
    end
  end

  fpst_ctrl_decode #(.RM_W(RM_W)) u_dec (
    .rm_i        (status_q[RM_LSB +: RM_W]),
    .dnorm_i     (status_q[D_POS]),
    .round_oh_o  (round_oh_o),
    .flush_in_o  (flush_in_o),
    .flush_out_o (flush_out_o)
  );

  assign status_o  = status_q;
  assign exc_rec_o = rec_q;
  assign trap_o    = trap_q;

  AST_NOFLAG_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(op_done_i && !sw_we_i && raised_i == '0)) |-> (rec_q == '0 && !trap_q)); // R2
  AST_HIGH_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(op_done_i && !sw_we_i)) |-> (status_q[W-1:KEEP_W] == '0)); // R3
  AST_TRAP_SETS_T: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_q |-> status_q[T_POS]); // R4
  AST_OVF_RECORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_q && $past(raised_i[F_OVF] | raised_i[F_UNF])) |-> ($countones(rec_q) == 2 && rec_q[REC_C_POS] && rec_q[REC_FLG_LSB+F_OVF])); // R5
  AST_ROUND_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(round_oh_o) == 1); // R8
  AST_TRAP_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_q |-> $past(op_done_i && !sw_we_i)); // R11
endmodule

// File: tb/tb_fpst_unit.sv
`timescale 1ns/1ps
module tb_fpst_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_done = 1'b0;
  logic [4:0]  raised = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] status, rec;
  logic        trap;
  logic [3:0]  rnd;
  logic        fl_in, fl_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [31:0] m_status = '0;
  logic [31:0] m_rec    = '0;
  logic        m_trap   = 1'b0;

  always #2.5 clk = ~clk;

  fpst_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .op_done_i(op_done), .raised_i(raised),
    .sw_we_i(we), .sw_wdata_i(wdata), .status_o(status), .exc_rec_o(rec),
    .trap_o(trap), .round_oh_o(rnd), .flush_in_o(fl_in), .flush_out_o(fl_out)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_record(logic [4:0] fl, logic [31:0] st);
    logic [31:0] r = '0;
    if ((fl & st[4:0]) != 0) begin
      if (fl[1] | fl[2]) r = (32'h1 << 26) | (32'h1 << 29);
      else               r = {fl, 27'h0};
    end
    return r;
  endfunction

  task automatic step(bit w, logic [31:0] wd, bit od, logic [4:0] fl);
    string rtag, ttag;
    bit    hit;
    we = w; wdata = wd; op_done = od; raised = fl;
    hit  = (fl & m_status[4:0]) != 0;
    rtag = "R10";
    ttag = "R11";
    if (w) begin
      m_status = wd;
      m_trap   = 1'b0;
    end else if (od) begin
      m_rec  = exp_record(fl, m_status);
      m_trap = hit;
      m_status = m_status & 32'h03FF_FFFF;
      if (hit) m_status[6] = 1'b1;
      if (fl == 0)              rtag = "R2";
      else if (!hit)            rtag = "R7";
      else if (fl[1] | fl[2])   rtag = "R5";
      else                      rtag = "R6";
      ttag = hit ? "R4" : "R11";
    end else begin
      m_trap = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    we = 1'b0; op_done = 1'b0; raised = '0;
    chk((od && !w) ? "R3" : "R10", status, m_status);
    chk(rtag, rec, m_rec);
    chk(ttag, {31'h0, trap}, {31'h0, m_trap});
    chk("R8", {28'h0, rnd}, 32'h1 << m_status[10:9]);
    chk("R9", {30'h0, fl_out, fl_in}, {30'h0, m_status[5], m_status[5]});
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    #12;
    // R1 reset state
    chk("R1", status, 32'h0);
    chk("R1", rec, 32'h0);
    chk("R1", {31'h0, trap}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {28'h0, rnd}, 32'h1);
    chk("R1", {30'h0, fl_out, fl_in}, 32'h0);

    // R10 load with upper bits, toward-zero, flush on, all enables
    step(1, 32'hFC00_023F, 0, 5'h0);
    step(0, 32'h0, 1, 5'h00);            // R2, R3 clears high bits
    step(0, 32'h0, 1, 5'b00100);         // R5 overflow
    step(0, 32'h0, 0, 5'h0);             // R11 trap drops
    step(1, 32'h0000_0001, 0, 5'h0);     // only inexact enabled
    step(0, 32'h0, 1, 5'b00011);         // R5 inexact trap with underflow raised
    step(1, 32'h0000_0418, 0, 5'h0);     // rm=2, enables Z,V
    step(0, 32'h0, 1, 5'b11001);         // R6 record = raw flags
    step(1, 32'h0000_0600, 0, 5'h0);     // rm=3, no enables
    step(0, 32'h0, 1, 5'b11111);         // R7 nothing enabled
    step(1, 32'h0000_001F, 1, 5'b11111); // R10 write wins over op
    step(0, 32'h0, 1, 5'b10000);         // R6 back-to-back traps
    step(0, 32'h0, 1, 5'b01000);

    for (int i = 0; i < 3000; i++) begin
      int unsigned kind = $urandom_range(0, 9);
      logic [4:0] f = (kind < 2) ? 5'h0 : 5'($urandom);
      if (kind == 9)      step(1, $urandom, $urandom_range(0, 1), f);
      else if (kind == 8) step(0, 32'h0, 0, 5'h0);
      else                step(0, 32'h0, 1, f);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule